// File: doc/BRIEF.md
# Dual-Direction Latched Bus Transceiver

The block moves data between an A bus and a B bus through two banks of latches, one bank per direction. The bus is split into independent groups (two groups of eight bits by default). Each group has its own set of three active-low controls per direction: a select, a latch control and a drive control. Because the block sits inside a clocked chip, the latches are modelled synchronously. Holding the latch control low while the group is selected makes the path transparent: the output follows the input in the same cycle, and the latch copies the input at every clock edge. Raising the latch control freezes the copy taken at the last edge.

Each bus side is presented as a data vector plus a per-bit drive vector instead of a tri-state pin. A wrapper at the pad level can turn a cleared drive bit into high impedance. Data bits that are not driven read as zero. An asynchronous active-low reset clears both latch banks. It exists so that tests start from a known state.

Every direction of every group contains a small mode machine with three states. OFF means the group is not selected. PASS means it is selected with the latch open. HOLD means it is selected with the latch closed. The transitions are: SELECT (OFF to PASS or HOLD), DESELECT (PASS or HOLD to OFF), OPEN (HOLD to PASS) and CAPTURE (PASS to HOLD). CAPTURE is the transition that fixes the stored value.

Top module: `dlxcvr_top`

## Requirements
- R1: After reset every latch holds zero. A selected group that is driving with its latch closed therefore outputs zero until new data is captured.
- R2: A drive bit is 1 exactly when the group's select and drive controls for that direction are both low (0 = no drive). This applies per group: bits [7:0] belong to group 0 and bits [15:8] to group 1.
- R3: With the group selected, the latch control low and the drive control low, the output equals the current input in the same cycle.
- R4: Raising the latch control while the group is selected keeps the input value sampled at the last clock edge before the rise. Later input changes do not alter the output.
- R5: While a group's select is high, its latch keeps its content whatever the latch control and input do, and its drive bits are 0.
- R6: While the drive control is high the outputs are off, but the latch still tracks and captures. The captured value appears once the drive control goes low.
- R7: The B-to-A direction behaves like A-to-B, using its own controls and its own latch bank.
- R8: Groups are independent. Controls and data of one group never change the outputs of the other.
- R9: An output data bit whose drive bit is 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears latches |
| a_in | input | 16 | Data arriving on the A side |
| b_in | input | 16 | Data arriving on the B side |
| sel_ab_n | input | 2 | Per-group A-to-B select, active low |
| lat_ab_n | input | 2 | Per-group A-to-B latch control, low = transparent |
| drv_ab_n | input | 2 | Per-group A-to-B drive control, active low |
| sel_ba_n | input | 2 | Per-group B-to-A select, active low |
| lat_ba_n | input | 2 | Per-group B-to-A latch control, low = transparent |
| drv_ba_n | input | 2 | Per-group B-to-A drive control, active low |
| b_out | output | 16 | Data presented to the B side |
| b_drv | output | 16 | Per-bit drive enable for the B side |
| a_out | output | 16 | Data presented to the A side |
| a_drv | output | 16 | Per-bit drive enable for the A side |

## Verification
The hardest case to reach is a capture made while the drive control is high. The output reads zero during the capture, so the latch content cannot be seen until a later cycle enables drive. The stimulus opens the latch with drive off and lets a clock edge pass. It then closes the latch and changes the input in the same step, and only afterwards lowers the drive control and compares against the earlier value. A similar hidden-state sequence toggles the latch control while the group is deselected and then shows that the old content survived.

// File: rtl/dlxcvr_pkg.sv
`timescale 1ns/1ps
package dlxcvr_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_PASS = 2'd1,
        MODE_HOLD = 2'd2
    } lane_mode_t;

endpackage

// File: rtl/dlxcvr_lane.sv
`timescale 1ns/1ps
module dlxcvr_lane
    import dlxcvr_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANE_W-1:0] din,
    input  logic              sel_n,
    input  logic              lat_n,
    input  logic              drv_n,
    output logic [LANE_W-1:0] dout,
    output logic [LANE_W-1:0] drv
);

    lane_mode_t           mode_d;
    lane_mode_t           mode_q;
    logic [LANE_W-1:0]    store_q;
    logic                 drive_on;
    logic [LANE_W-1:0]    view;

    // Next mode from the controls
    always_comb begin
        unique casez ({sel_n, lat_n})
            2'b1?:   mode_d = MODE_OFF;
            2'b00:   mode_d = MODE_PASS;
            2'b01:   mode_d = MODE_HOLD;
            default: mode_d = MODE_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_OFF;
        else        mode_q <= mode_d;
    end

    // Latch bank: tracks input in PASS
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  store_q <= '0;
        else if (mode_d == MODE_PASS) store_q <= din;
    end

    // Outputs
    always_comb begin
        drive_on = ~sel_n & ~drv_n;
        unique case (mode_d)
            MODE_PASS: view = din;
            MODE_HOLD: view = store_q;
            MODE_OFF:  view = store_q;
            default:   view = store_q;
        endcase
        dout = drive_on ? view : '0;
        drv  = {LANE_W{drive_on}};
    end

    // CAPTURE keeps the value of the last open edge
    assert_capture_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PASS && mode_d == MODE_HOLD && !drv_n) |-> dout == $past(din));

    // Deselected latch does not change
    assert_deselect_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> $stable(store_q));

    // Drive control high still lets the latch track
    assert_hidden_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !lat_n && drv_n) |=> store_q == $past(din));

endmodule

// File: rtl/dlxcvr_group.sv
`timescale 1ns/1ps
module dlxcvr_group #(
    parameter int GRP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GRP_W-1:0] a_in,
    input  logic [GRP_W-1:0] b_in,
    input  logic             sel_ab_n,
    input  logic             lat_ab_n,
    input  logic             drv_ab_n,
    input  logic             sel_ba_n,
    input  logic             lat_ba_n,
    input  logic             drv_ba_n,
    output logic [GRP_W-1:0] b_out,
    output logic [GRP_W-1:0] b_drv,
    output logic [GRP_W-1:0] a_out,
    output logic [GRP_W-1:0] a_drv
);

    dlxcvr_lane #(.LANE_W(GRP_W)) u_ab (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (a_in),
        .sel_n (sel_ab_n),
        .lat_n (lat_ab_n),
        .drv_n (drv_ab_n),
        .dout  (b_out),
        .drv   (b_drv)
    );

    dlxcvr_lane #(.LANE_W(GRP_W)) u_ba (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (b_in),
        .sel_n (sel_ba_n),
        .lat_n (lat_ba_n),
        .drv_n (drv_ba_n),
        .dout  (a_out),
        .drv   (a_drv)
    );

    // Mirror direction is transparent the same way
    assert_ba_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ba_n && !lat_ba_n && !drv_ba_n) |-> a_out == b_in);

endmodule

// File: rtl/dlxcvr_top.sv
`timescale 1ns/1ps
module dlxcvr_top #(
    parameter int GRP_W  = 8,
    parameter int GROUPS = 2,
    localparam int BUS_W = GRP_W * GROUPS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  a_in,
    input  logic [BUS_W-1:0]  b_in,
    input  logic [GROUPS-1:0] sel_ab_n,
    input  logic [GROUPS-1:0] lat_ab_n,
    input  logic [GROUPS-1:0] drv_ab_n,
    input  logic [GROUPS-1:0] sel_ba_n,
    input  logic [GROUPS-1:0] lat_ba_n,
    input  logic [GROUPS-1:0] drv_ba_n,
    output logic [BUS_W-1:0]  b_out,
    output logic [BUS_W-1:0]  b_drv,
    output logic [BUS_W-1:0]  a_out,
    output logic [BUS_W-1:0]  a_drv
);

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        dlxcvr_group #(.GRP_W(GRP_W)) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .a_in     (a_in[g*GRP_W +: GRP_W]),
            .b_in     (b_in[g*GRP_W +: GRP_W]),
            .sel_ab_n (sel_ab_n[g]),
            .lat_ab_n (lat_ab_n[g]),
            .drv_ab_n (drv_ab_n[g]),
            .sel_ba_n (sel_ba_n[g]),
            .lat_ba_n (lat_ba_n[g]),
            .drv_ba_n (drv_ba_n[g]),
            .b_out    (b_out[g*GRP_W +: GRP_W]),
            .b_drv    (b_drv[g*GRP_W +: GRP_W]),
            .a_out    (a_out[g*GRP_W +: GRP_W]),
            .a_drv    (a_drv[g*GRP_W +: GRP_W])
        );

        assert_off_no_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
            sel_ab_n[g] |-> b_drv[g*GRP_W +: GRP_W] == '0);

        assert_pass_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!sel_ab_n[g] && !lat_ab_n[g] && !drv_ab_n[g])
                |-> b_out[g*GRP_W +: GRP_W] == a_in[g*GRP_W +: GRP_W]);
    end

    assert_quiet_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((b_out & ~b_drv) == '0) && ((a_out & ~a_drv) == '0));

endmodule

// File: tb/dlxcvr_top_bench.sv
`timescale 1ns/1ps
module dlxcvr_top_bench;

    typedef struct {
        string       req;
        int          sel;
        logic [15:0] mask;
        logic [15:0] exp;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a_in = '0, b_in = '0;
    logic [1:0]  sel_ab_n = 2'b11, lat_ab_n = 2'b11, drv_ab_n = 2'b11;
    logic [1:0]  sel_ba_n = 2'b11, lat_ba_n = 2'b11, drv_ba_n = 2'b11;
    logic [15:0] b_out, b_drv, a_out, a_drv;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    item_t q[$];
    event mon_ev;

    always #4 clk = ~clk;

    dlxcvr_top u_dlxcvr_top (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .sel_ab_n(sel_ab_n), .lat_ab_n(lat_ab_n), .drv_ab_n(drv_ab_n),
        .sel_ba_n(sel_ba_n), .lat_ba_n(lat_ba_n), .drv_ba_n(drv_ba_n),
        .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv)
    );

    task automatic want(string r, int s, logic [15:0] m, logic [15:0] v);
        item_t it;
        it.req = r; it.sel = s; it.mask = m; it.exp = v;
        q.push_back(it);
    endtask

    task automatic settle();
        #2;
        for (int g = 0; g < 2; g++) begin
            if (b_drv[g*8] && a_drv[g*8]) begin
                n_chk++; n_bad++;
                $display("FAIL contention group %0d: both directions driving (actual 1, expected 0)", g);
            end
        end
        ->mon_ev;
        #1;
    endtask

    task automatic neg();
        @(negedge clk);
    endtask

    // Monitor: pop and compare
    initial begin
        forever begin
            @(mon_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = q.pop_front();
                case (it.sel)
                    0: act = b_out;
                    1: act = b_drv;
                    2: act = a_out;
                    default: act = a_drv;
                endcase
                n_chk++;
                if ((act & it.mask) != (it.exp & it.mask)) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.req, act & it.mask, it.exp & it.mask);
                end
            end
        end
    end

    initial begin
        #(8 * 5000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        // Reset state, R1 and R9
        neg();
        want("R9", 0, 16'hFFFF, 16'h0000);
        want("R2", 1, 16'hFFFF, 16'h0000);
        want("R2", 3, 16'hFFFF, 16'h0000);
        settle();
        neg(); rst_n = 1'b1;
        neg();
        sel_ab_n[0] = 1'b0; lat_ab_n[0] = 1'b1; drv_ab_n[0] = 1'b0; a_in = 16'hABCD;
        want("R1", 0, 16'h00FF, 16'h0000);
        want("R2", 1, 16'hFFFF, 16'h00FF);
        settle();

        // R3 transparent
        neg(); lat_ab_n[0] = 1'b0; a_in = 16'h1234;
        want("R3", 0, 16'h00FF, 16'h0034);
        settle();
        neg(); a_in = 16'h0056;
        want("R3", 0, 16'h00FF, 16'h0056);
        settle();

        // R4 capture
        neg(); lat_ab_n[0] = 1'b1; a_in = 16'h009A;
        want("R4", 0, 16'h00FF, 16'h0056);
        settle();
        neg(); a_in = 16'h00FF;
        want("R4", 0, 16'h00FF, 16'h0056);
        settle();

        // R5 deselected latch ignores latch control and data
        neg(); sel_ab_n[0] = 1'b1; lat_ab_n[0] = 1'b0; a_in = 16'h0011;
        want("R5", 1, 16'h00FF, 16'h0000);
        want("R9", 0, 16'h00FF, 16'h0000);
        settle();
        neg(); lat_ab_n[0] = 1'b1; a_in = 16'h0022;
        neg(); sel_ab_n[0] = 1'b0;
        want("R5", 0, 16'h00FF, 16'h0056);
        settle();

        // R6 capture while drive off
        neg(); drv_ab_n[0] = 1'b1; lat_ab_n[0] = 1'b0; a_in = 16'h0077;
        want("R6", 1, 16'h00FF, 16'h0000);
        want("R6", 0, 16'h00FF, 16'h0000);
        settle();
        neg(); lat_ab_n[0] = 1'b1; a_in = 16'h0000;
        neg(); drv_ab_n[0] = 1'b0;
        want("R6", 0, 16'h00FF, 16'h0077);
        settle();

        // R8 group 1 independent
        neg(); sel_ab_n[1] = 1'b0; lat_ab_n[1] = 1'b0; drv_ab_n[1] = 1'b0; a_in = 16'hC300;
        want("R8", 0, 16'hFFFF, 16'hC377);
        want("R8", 1, 16'hFFFF, 16'hFFFF);
        settle();

        // R7 B-to-A on group 1
        neg(); sel_ab_n[1] = 1'b1;
        sel_ba_n[1] = 1'b0; lat_ba_n[1] = 1'b0; drv_ba_n[1] = 1'b0; b_in = 16'h5A00;
        want("R7", 2, 16'hFF00, 16'h5A00);
        want("R7", 3, 16'hFFFF, 16'hFF00);
        settle();
        neg(); lat_ba_n[1] = 1'b1; b_in = 16'h0000;
        want("R7", 2, 16'hFF00, 16'h5A00);
        settle();
        neg(); drv_ba_n[1] = 1'b1;
        want("R7", 3, 16'hFF00, 16'h0000);
        want("R9", 2, 16'hFF00, 16'h0000);
        settle();

        // R8 group 0 still holds 77 on B
        neg();
        want("R8", 0, 16'h00FF, 16'h0077);
        settle();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule